// File: doc/BRIEF.md
# Doorbell and MSI Trigger Unit

This block turns single register writes into pending doorbell interrupts for a small group of processors. Software that wants to interrupt other processors writes one trigger word. That word names a doorbell number and holds a bitmap of the processors that should receive it. A PCI message-signalled interrupt arrives the same way, as a plain write of a fixed pattern to the same trigger word. The block records each doorbell in a per-processor cause register. It filters the cause register through a per-processor mask and drives two request lines per processor: one for the low (inter-processor) doorbell field and one for the high (message-signalled) field. These lines feed interrupt sources 0 and 1 of a downstream interrupt controller.

Every write port accepts its write in the cycle it is strobed. There is no back-pressure and no valid/ready handshake, because each write completes in a single clock. State is read back through a combinational read port. The request lines are driven directly from registers ANDed with the mask, so they change in the cycle after the write that caused the change.

Top module: `db_unit`

## Requirements
- R1: After reset every cause and mask bit of every processor reads 0, and all request lines are low.
- R2: A trigger write with doorbell number d in 0..7 (bits [4:0] of the word) sets cause bit d of each processor c whose bitmap bit 8+c is 1. Other processors and other cause bits keep their values.
- R3: A trigger write with doorbell number d in 16..31 sets cause bit d of the targeted processors. The message pattern 0xF00 | (16+m) sets bit 16+m on all four processors.
- R4: A trigger write with doorbell number 8..15 changes no cause bit on any processor.
- R5: A write to a processor's cause register (per-processor offset 0x8) clears each bit written as 0 and keeps each bit written as 1. Other processors are not touched.
- R6: A write to a processor's mask register (offset 0xC) loads it. Bits [15:8] of both cause and mask always read 0.
- R7: irq_ipi[c] is high exactly when some bit in [7:0] is set in both cause and mask of processor c.
- R8: irq_msi[c] is high exactly when some bit in [31:16] is set in both cause and mask of processor c.
- R9: When a trigger write sets a bit in the same cycle that a cause write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_data | input | 32 | Trigger word: doorbell number [4:0], processor bitmap from bit 8 |
| pc_we | input | 1 | Per-processor register write strobe |
| pc_cpu | input | 2 | Processor addressed by the write |
| pc_addr | input | 4 | Register offset: 0x8 cause, 0xC mask, others ignored |
| pc_wdata | input | 32 | Per-processor write data |
| rd_cpu | input | 2 | Processor addressed by the read |
| rd_addr | input | 4 | Read offset: 0x8 cause, 0xC mask, others read 0 |
| rd_data | output | 32 | Combinational read data |
| irq_ipi | output | 4 | Per-processor request for the low doorbell field |
| irq_msi | output | 4 | Per-processor request for the high doorbell field |

## Verification
The hardest case to reach is the collision, where a trigger sets a bit in the same clock that a cause write clears it. The bench gets there by driving both strobes on one falling edge, with a cause write of all zeros aimed at a targeted processor. It then reads back a single surviving bit. The ignored doorbell range and the per-processor isolation of cause writes are checked by reading back all four processors after each write. The request lines are checked against a bench model both before and after the mask opens.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int DB_W     = 32;
  localparam int IPI_LO   = 0;
  localparam int IPI_N    = 8;
  localparam int MSI_LO   = 16;
  localparam int MSI_N    = 16;
  localparam int NUM_W    = 5;
  localparam int MAP_LO   = 8;
  localparam logic [3:0] OFF_CAUSE = 4'h8;
  localparam logic [3:0] OFF_MASK  = 4'hC;

  // Bits that physically exist in cause and mask storage.
  function automatic logic [DB_W-1:0] impl_bits();
    logic [DB_W-1:0] m;
    m = '0;
    for (int i = 0; i < DB_W; i++)
      if ((i >= IPI_LO && i < IPI_LO + IPI_N) || (i >= MSI_LO && i < MSI_LO + MSI_N))
        m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DB_W-1:0] ipi_field();
    logic [DB_W-1:0] m;
    m = '0;
    for (int i = IPI_LO; i < IPI_LO + IPI_N; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DB_W-1:0] msi_field();
    logic [DB_W-1:0] m;
    m = '0;
    for (int i = MSI_LO; i < MSI_LO + MSI_N; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
  import db_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                      trig_we,
  input  logic [DB_W-1:0]           trig_data,
  output logic [NCPU-1:0][DB_W-1:0] set_bits
);
  localparam logic [DB_W-1:0] IMPL = impl_bits();

  logic [NUM_W-1:0] num;
  logic [DB_W-1:0]  onehot;
  logic [NCPU-1:0]  targets;

  assign num     = trig_data[NUM_W-1:0];
  assign targets = trig_data[MAP_LO +: NCPU];

  always_comb begin
    onehot = '0;
    onehot[num] = 1'b1;
    // Numbers that name unimplemented bits decode to nothing.
    onehot = onehot & IMPL;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_tgt
    assign set_bits[c] = (trig_we && targets[c]) ? onehot : '0;
  end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
  import db_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] set_bits,
  input  logic            clr_we,
  input  logic            mask_we,
  input  logic [DB_W-1:0] wdata,
  output logic [DB_W-1:0] cause_q,
  output logic [DB_W-1:0] mask_q,
  output logic            irq_ipi,
  output logic            irq_msi
);
  localparam logic [DB_W-1:0] IMPL = impl_bits();
  localparam logic [DB_W-1:0] FLD_IPI = ipi_field();
  localparam logic [DB_W-1:0] FLD_MSI = msi_field();

  logic [DB_W-1:0] cause_d;
  logic [DB_W-1:0] live;

  always_comb begin
    cause_d = cause_q;
    if (clr_we) cause_d = cause_q & wdata;
    cause_d = (cause_d | set_bits) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (mask_we) mask_q <= wdata & IMPL;
    end
  end

  assign live    = cause_q & mask_q;
  assign irq_ipi = |(live & FLD_IPI);
  assign irq_msi = |(live & FLD_MSI);

  // R9: a bit driven by the decoder is present next cycle even under a clear.
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((cause_q & $past(set_bits)) == $past(set_bits)));

  // R5: bits written as 0 without a concurrent set are gone next cycle.
  a_r5_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((cause_q & ~$past(wdata) & ~$past(set_bits)) == '0));

  // R5: with no write and no set the cause register holds.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && set_bits == '0) |=> $stable(cause_q));

  // R7: the IPI request can only rise after a set or a mask write.
  a_r7_ipi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ipi) |-> $past(mask_we || set_bits != '0));

  // R8: the MSI request can only rise after a set or a mask write.
  a_r8_msi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_msi) |-> $past(mask_we || set_bits != '0));
endmodule

// File: rtl/db_read_mux.sv
module db_read_mux
  import db_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic [NCPU-1:0][DB_W-1:0] cause_all,
  input  logic [NCPU-1:0][DB_W-1:0] mask_all,
  input  logic [CPU_W-1:0]          rd_cpu,
  input  logic [3:0]                rd_addr,
  output logic [DB_W-1:0]           rd_data
);
  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (rd_cpu == CPU_W'(c)) begin
        if (rd_addr == OFF_CAUSE)     rd_data = cause_all[c];
        else if (rd_addr == OFF_MASK) rd_data = mask_all[c];
      end
    end
  end
endmodule

// File: rtl/db_unit.sv
module db_unit
  import db_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = $clog2(NCPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_we,
  input  logic [31:0]      trig_data,
  input  logic             pc_we,
  input  logic [CPU_W-1:0] pc_cpu,
  input  logic [3:0]       pc_addr,
  input  logic [31:0]      pc_wdata,
  input  logic [CPU_W-1:0] rd_cpu,
  input  logic [3:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [NCPU-1:0]  irq_ipi,
  output logic [NCPU-1:0]  irq_msi
);
  logic [NCPU-1:0][DB_W-1:0] set_bits;
  logic [NCPU-1:0][DB_W-1:0] cause_all;
  logic [NCPU-1:0][DB_W-1:0] mask_all;

  db_trig_decode #(.NCPU(NCPU)) u_dec (
    .trig_we  (trig_we),
    .trig_data(trig_data),
    .set_bits (set_bits)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic sel;
    assign sel = pc_we && (pc_cpu == CPU_W'(c));
    db_cpu_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_bits(set_bits[c]),
      .clr_we  (sel && pc_addr == OFF_CAUSE),
      .mask_we (sel && pc_addr == OFF_MASK),
      .wdata   (pc_wdata),
      .cause_q (cause_all[c]),
      .mask_q  (mask_all[c]),
      .irq_ipi (irq_ipi[c]),
      .irq_msi (irq_msi[c])
    );
  end

  db_read_mux #(.NCPU(NCPU), .CPU_W(CPU_W)) u_rd (
    .cause_all(cause_all),
    .mask_all (mask_all),
    .rd_cpu   (rd_cpu),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  // R4: a trigger naming 8..15 leaves every cause register unchanged.
  a_r4_mid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data[4:3] == 2'b01 && !pc_we) |=> $stable(cause_all));

  // R1: the cycle after reset, no request line is active.
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (irq_ipi == '0 && irq_msi == '0));
endmodule

// File: tb/sim_db_unit.sv
`timescale 1ns/100ps
module sim_db_unit;
  localparam int NCPU = 4;
  localparam logic [31:0] IMPL = 32'hFFFF_00FF;

  logic clk = 0;
  logic rst_n = 0;
  logic trig_we = 0;
  logic [31:0] trig_data = '0;
  logic pc_we = 0;
  logic [1:0] pc_cpu = '0;
  logic [3:0] pc_addr = '0;
  logic [31:0] pc_wdata = '0;
  logic [1:0] rd_cpu = '0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0] irq_ipi, irq_msi;

  always #2.5 clk = ~clk;

  db_unit u0 (.*);

  typedef struct {
    int          cpu;
    logic [31:0] cause;
    logic [31:0] mask;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] m_cause [NCPU];
  logic [31:0] m_mask  [NCPU];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected snapshots and compares against the ports.
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        exp_t it;
        logic [31:0] live;
        it = q.pop_front();
        rd_cpu = it.cpu[1:0];
        rd_addr = 4'h8;
        #0.1;
        chk({it.tag, " cause"}, rd_data, it.cause);
        rd_addr = 4'hC;
        #0.1;
        chk({it.tag, " mask"}, rd_data, it.mask);
        live = it.cause & it.mask;
        chk({it.tag, " ipi"}, {31'd0, irq_ipi[it.cpu]}, {31'd0, |live[7:0]});
        chk({it.tag, " msi"}, {31'd0, irq_msi[it.cpu]}, {31'd0, |live[31:16]});
      end
    end
  end

  task automatic push_all(string tag);
    for (int c = 0; c < NCPU; c++) begin
      exp_t it;
      it.cpu = c; it.cause = m_cause[c]; it.mask = m_mask[c]; it.tag = tag;
      q.push_back(it);
    end
    wait (q.size() == 0);
    #0.3;
  endtask

  task automatic model_trig(logic [31:0] w);
    int d;
    d = int'(w[4:0]);
    for (int c = 0; c < NCPU; c++)
      if (w[8+c] && (d < 8 || d >= 16)) m_cause[c][d] = 1'b1;
  endtask

  // Driver: applies one step, updates the model, queues expectations.
  task automatic step(string tag, bit t_en, logic [31:0] tw,
                      bit p_en, int pcpu, logic [3:0] pa, logic [31:0] pw);
    @(negedge clk);
    trig_we = t_en; trig_data = tw;
    pc_we = p_en; pc_cpu = pcpu[1:0]; pc_addr = pa; pc_wdata = pw;
    @(posedge clk);
    #1;
    trig_we = 0; pc_we = 0;
    if (p_en && pa == 4'h8) m_cause[pcpu] = m_cause[pcpu] & pw & IMPL;
    if (p_en && pa == 4'hC) m_mask[pcpu] = pw & IMPL;
    if (t_en) model_trig(tw);
    push_all(tag);
  endtask

  initial begin
    for (int c = 0; c < NCPU; c++) begin m_cause[c] = '0; m_mask[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #0.5;
    push_all("R1 reset");
    // R2: IPI doorbell 3 to cpus 0 and 2, mask still closed (R7 gating)
    step("R2 ipi set", 1, 32'h0000_0503, 0, 0, 4'h0, 0);
    step("R7 mask closed", 1, 32'h0000_0207, 0, 0, 4'h0, 0);
    step("R7 mask open", 0, 0, 1, 0, 4'hC, 32'h0000_0008);
    step("R6 mask mid bits", 0, 0, 1, 2, 4'hC, 32'hFFFF_FFFF);
    // R3: message pattern for m=0 and m=15
    step("R3 msi m0", 1, 32'h0000_0F10, 0, 0, 4'h0, 0);
    step("R3 msi m15", 1, 32'h0000_0F1F, 0, 0, 4'h0, 0);
    step("R8 msi mask", 0, 0, 1, 1, 4'hC, 32'h0001_0000);
    // R4: numbers 8..15 ignored
    step("R4 mid 8", 1, 32'h0000_0F08, 0, 0, 4'h0, 0);
    step("R4 mid 15", 1, 32'h0000_0F0F, 0, 0, 4'h0, 0);
    // R5: clear zeros on cpu 2 only, keep bit 3 and bit 31
    step("R5 clear", 0, 0, 1, 2, 4'h8, 32'h8000_0008);
    step("R5 clear all", 0, 0, 1, 0, 4'h8, 32'h0000_0000);
    step("R5 bad offset", 0, 0, 1, 1, 4'h4, 32'h0000_0000);
    // R9: trigger bit 5 to cpu 3 while cpu 3 is cleared with zeros
    step("R9 set wins", 1, 32'h0000_0805, 1, 3, 4'h8, 32'h0000_0000);
    step("R7 ipi mask cpu3", 0, 0, 1, 3, 4'hC, 32'h0000_0020);
    step("R2 accumulate", 1, 32'h0000_0F00, 0, 0, 4'h0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule